// File: doc/BRIEF.md
# Stack and Status-Flag Execution Unit

This unit carries out the 8-bit processor's single-byte instructions that work on the hardware stack, the status register, and the register-to-register moves that involve the stack pointer. It also carries out the bit-test operation on an operand that has already been fetched. It holds the accumulator, the X index register, the stack pointer and the status register.

An upstream decoder presents a 4-bit operation code and pulses `start`. The unit then steps through a fixed number of cycles. It reaches the stack through a plain synchronous memory port, where read data returns one cycle after the address. It raises `done` for one clock on the last cycle of the instruction. The updated registers appear on the outputs in the cycle after `done`.

The unit has no streaming data path, so there is no valid/ready handshake. `start`, `done` and `busy` are plain control pins. The unit never stalls, and the memory port is assumed to answer every access in a fixed time.

Top module: `stk_flag_unit`

## Requirements
- R1: After reset the outputs read A=0x00, X=0x00, S=0xFD and P=0x24, with `done` and `mem_we` low. The status bit positions are C=0, Z=1, I=2, D=3, break=4, constant=5, V=6, N=7.
- R2: The cycle in which `start` is sampled counts as cycle 1. `done` is high for exactly one clock, on the last cycle. Push operations (PHA=1, PHP=2, BRK push=8) take 3 cycles. Pull operations (PLA=3, PLP=4) take 4 cycles. All other operation codes take 2 cycles.
- R3: A `start` that arrives while `busy` is high is ignored. It launches no instruction and changes no register.
- R4: A push writes to address 0x0100+S in its `done` cycle and then decrements S. PHA (code 1) writes A.
- R5: PHP (code 2) writes P with bits 4 and 5 set and leaves the live P unchanged.
- R6: A pull first increments S, then reads 0x0100+S. PLA (code 3) loads A from the read byte and sets N to bit 7 of that byte and Z to whether the byte is zero.
- R7: PLP (code 4) loads P from the pulled byte with bit 4 cleared and bit 5 set.
- R8: TXS (code 5) copies X into S and leaves P unchanged. TSX (code 6) copies S into X and sets N and Z from the new X.
- R9: BIT (code 7) sets N to `operand` bit 7 and V to `operand` bit 6. It sets Z when A AND `operand` is zero. It leaves the other bits of P unchanged.
- R10: BRK push (code 8) pushes P with bits 4 and 5 set and with the I value from before the instruction, then sets I.
- R11: SEC=9 and SEI=13 set C and I respectively. SED=11 sets D. CLC=10, CLD=12, CLI=14 and CLV=15 clear C, D, I and V respectively. Each of these changes no other bit. NOP (code 0) changes nothing.
- R12: S wraps modulo 256. A push at S=0x00 writes 0x0100 and leaves S=0xFF. A pull at S=0xFF reads 0x0100 and leaves S=0x00.
- R13: P always reads bit 5 as 1 and bit 4 as 0, whatever byte is pulled into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, sampled only while idle |
| op_code | input | 4 | Operation code, sampled with `start` |
| operand | input | 8 | Fetched operand for BIT |
| mem_addr | output | 16 | Stack address, page 0x01 plus S |
| mem_wdata | output | 8 | Byte to push |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of an instruction |
| a_out | output | 8 | Accumulator |
| x_out | output | 8 | X index register |
| s_out | output | 8 | Stack pointer |
| p_out | output | 8 | Status register |

## Verification
The assertions assume that `operand` is held stable from `start` through the `done` cycle of a bit test. They also assume that `mem_rdata` carries the byte at the address presented one cycle before. The bench drives `operand` together with `start` and does not change it until the next instruction. Its stack memory model registers the read data once per clock. Both assumptions therefore always hold. The bench probes the ignored-start rule by raising `start` in the middle of a push, and it reaches the wrap corner through a long run of pushes.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int DW = 8;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,  OP_PHA = 4'd1,  OP_PHP = 4'd2,  OP_PLA = 4'd3,
    OP_PLP = 4'd4,  OP_TXS = 4'd5,  OP_TSX = 4'd6,  OP_BIT = 4'd7,
    OP_BRK = 4'd8,  OP_SEC = 4'd9,  OP_CLC = 4'd10, OP_SED = 4'd11,
    OP_CLD = 4'd12, OP_SEI = 4'd13, OP_CLI = 4'd14, OP_CLV = 4'd15
  } op_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_I = 2;
  localparam int FL_D = 3;
  localparam int FL_B = 4;
  localparam int FL_K = 5;
  localparam int FL_V = 6;
  localparam int FL_N = 7;

  function automatic logic is_push(op_e o);
    return (o == OP_PHA) || (o == OP_PHP) || (o == OP_BRK);
  endfunction

  function automatic logic is_pull(op_e o);
    return (o == OP_PLA) || (o == OP_PLP);
  endfunction

  function automatic logic [2:0] op_len(op_e o);
    if (is_pull(o)) return 3'd4;
    if (is_push(o)) return 3'd3;
    return 3'd2;
  endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] op_in,
  output logic       busy,
  output op_e        op_q,
  output logic       fin,
  output logic       do_inc,
  output logic       do_push
);

  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] last_step;

  assign last_step = STEP_W'(op_len(op_q)) - STEP_W'(1);
  assign fin       = busy && (step == last_step);
  assign do_inc    = busy && is_pull(op_q) && (step == STEP_W'(1));
  assign do_push   = fin && is_push(op_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      op_q <= OP_NOP;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        step <= STEP_W'(1);
        op_q <= op_e'(op_in);
      end
    end else if (fin) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      step <= step + STEP_W'(1);
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !fin) || (op_len(op_q) == 3'd2));

endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [7:0]  PAGE   = 8'h01,
  parameter logic [7:0]  S_INIT = 8'hFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_q,
  input  logic              fin,
  input  logic              do_inc,
  input  logic              do_push,
  input  logic [DW-1:0]     p_in,
  input  logic [DW-1:0]     mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic [DW-1:0]     a,
  output logic [DW-1:0]     x,
  output logic [DW-1:0]     s,
  output logic              nz_ld,
  output logic [DW-1:0]     nz_val
);

  localparam int HI_W = ADDR_W - DW;

  assign mem_addr  = {HI_W'(PAGE), s};
  assign mem_we    = do_push;
  assign mem_wdata = (op_q == OP_PHA) ? a : (p_in | (DW'(1) << FL_B) | (DW'(1) << FL_K));

  assign nz_ld  = fin && ((op_q == OP_PLA) || (op_q == OP_TSX));
  assign nz_val = (op_q == OP_PLA) ? mem_rdata : s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a <= '0;
      x <= '0;
      s <= S_INIT;
    end else begin
      if (do_inc)  s <= s + DW'(1);
      if (do_push) s <= s - DW'(1);
      if (fin) begin
        case (op_q)
          OP_PLA:  a <= mem_rdata;
          OP_TSX:  x <= s;
          OP_TXS:  s <= x;
          default: ;
        endcase
      end
    end
  end

  p_push_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (s == $past(s) - 8'd1));

  p_pull_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_inc |=> (s == $past(s) + 8'd1));

  p_txs_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_TXS) |=> (s == $past(x)));

  p_push_page_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:DW] == HI_W'(PAGE)));

endmodule

// File: rtl/stk_flags.sv
module stk_flags
  import stk_pkg::*;
#(
  parameter logic P_I_INIT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op_q,
  input  logic          fin,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] a,
  input  logic          nz_ld,
  input  logic [DW-1:0] nz_val,
  output logic [DW-1:0] p
);

  logic f_n, f_v, f_d, f_i, f_z, f_c;

  always_comb begin
    p        = '0;
    p[FL_N]  = f_n;
    p[FL_V]  = f_v;
    p[FL_K]  = 1'b1;
    p[FL_B]  = 1'b0;
    p[FL_D]  = f_d;
    p[FL_I]  = f_i;
    p[FL_Z]  = f_z;
    p[FL_C]  = f_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_n <= 1'b0; f_v <= 1'b0; f_d <= 1'b0;
      f_i <= P_I_INIT; f_z <= 1'b0; f_c <= 1'b0;
    end else if (fin) begin
      if (nz_ld) begin
        f_n <= nz_val[DW-1];
        f_z <= (nz_val == '0);
      end
      case (op_q)
        OP_PLP: begin
          f_n <= mem_rdata[FL_N]; f_v <= mem_rdata[FL_V];
          f_d <= mem_rdata[FL_D]; f_i <= mem_rdata[FL_I];
          f_z <= mem_rdata[FL_Z]; f_c <= mem_rdata[FL_C];
        end
        OP_BIT: begin
          f_n <= operand[FL_N];
          f_v <= operand[FL_V];
          f_z <= ((a & operand) == '0);
        end
        OP_BRK: f_i <= 1'b1;
        OP_SEC: f_c <= 1'b1;
        OP_CLC: f_c <= 1'b0;
        OP_SED: f_d <= 1'b1;
        OP_CLD: f_d <= 1'b0;
        OP_SEI: f_i <= 1'b1;
        OP_CLI: f_i <= 1'b0;
        OP_CLV: f_v <= 1'b0;
        default: ;
      endcase
    end
  end

  p_bit_nv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_BIT) |=>
      (p[7:6] == $past(operand[7:6])) && (p[5:2] == $past(p[5:2])) && (p[0] == $past(p[0])));

  p_php_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && (op_q == OP_PHP || op_q == OP_PHA || op_q == OP_TXS || op_q == OP_NOP)) |=> (p == $past(p)));

  p_brk_sets_i_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_BRK) |=> p[FL_I] && (p[7:3] == $past(p[7:3])) && (p[1:0] == $past(p[1:0])));

  p_sec_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_SEC) |=> p[FL_C] && (p[7:1] == $past(p[7:1])));

  p_clv_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_CLV) |=> !p[FL_V] && (p[7] == $past(p[7])) && (p[5:0] == $past(p[5:0])));

endmodule

// File: rtl/stk_flag_unit.sv
module stk_flag_unit
  import stk_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter logic [7:0] PAGE     = 8'h01,
  parameter logic [7:0] S_INIT   = 8'hFD,
  parameter logic       P_I_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op_code,
  input  logic [7:0]        operand,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [7:0]        a_out,
  output logic [7:0]        x_out,
  output logic [7:0]        s_out,
  output logic [7:0]        p_out
);

  op_e           op_q;
  logic          fin, do_inc, do_push, nz_ld;
  logic [DW-1:0] nz_val;

  stk_seq #(.STEP_W(3)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_code),
    .busy(busy), .op_q(op_q), .fin(fin), .do_inc(do_inc), .do_push(do_push)
  );

  stk_regs #(.ADDR_W(ADDR_W), .PAGE(PAGE), .S_INIT(S_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .fin(fin), .do_inc(do_inc),
    .do_push(do_push), .p_in(p_out), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .a(a_out), .x(x_out), .s(s_out), .nz_ld(nz_ld), .nz_val(nz_val)
  );

  stk_flags #(.P_I_INIT(P_I_INIT)) u_flags (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .fin(fin), .mem_rdata(mem_rdata),
    .operand(operand), .a(a_out), .nz_ld(nz_ld), .nz_val(nz_val), .p(p_out)
  );

  assign done = fin;

  p_brk_old_i_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && op_q == OP_BRK) |=> p_out[FL_I] && ($past(mem_wdata[FL_I]) == $past(p_out[FL_I])));

  p_done_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> done);

endmodule

// File: tb/test_stk_flag_unit.sv
module test_stk_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [7:0]  operand = 8'd0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, busy, done;
  logic [7:0]  a_out, x_out, s_out, p_out;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  stk_flag_unit i_stk_flag_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .operand(operand),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .a_out(a_out), .x_out(x_out), .s_out(s_out), .p_out(p_out)
  );

  logic [7:0] smem [256];
  always @(posedge clk) begin
    if (mem_we) smem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= smem[mem_addr[7:0]];
  end

  typedef struct packed {
    logic [3:0] op;  logic [7:0] opnd; logic [3:0] cyc;
    logic [7:0] a;   logic [7:0] x;    logic [7:0] s;  logic [7:0] p;
    logic       wr;  logic [7:0] wlo;  logic [7:0] wd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{4'd9,  8'h00, 4'd2, 8'h00, 8'h00, 8'hFD, 8'h25, 1'b0, 8'h00, 8'h00}, // SEC R11
    '{4'd2,  8'h00, 4'd3, 8'h00, 8'h00, 8'hFC, 8'h25, 1'b1, 8'hFD, 8'h35}, // PHP R5
    '{4'd6,  8'h00, 4'd2, 8'h00, 8'hFC, 8'hFC, 8'hA5, 1'b0, 8'h00, 8'h00}, // TSX R8
    '{4'd10, 8'h00, 4'd2, 8'h00, 8'hFC, 8'hFC, 8'hA4, 1'b0, 8'h00, 8'h00}, // CLC R11
    '{4'd3,  8'h00, 4'd4, 8'h35, 8'hFC, 8'hFD, 8'h24, 1'b0, 8'h00, 8'h00}, // PLA R6
    '{4'd7,  8'hC0, 4'd2, 8'h35, 8'hFC, 8'hFD, 8'hE6, 1'b0, 8'h00, 8'h00}, // BIT R9
    '{4'd7,  8'h01, 4'd2, 8'h35, 8'hFC, 8'hFD, 8'h24, 1'b0, 8'h00, 8'h00}, // BIT R9
    '{4'd1,  8'h00, 4'd3, 8'h35, 8'hFC, 8'hFC, 8'h24, 1'b1, 8'hFD, 8'h35}, // PHA R4
    '{4'd11, 8'h00, 4'd2, 8'h35, 8'hFC, 8'hFC, 8'h2C, 1'b0, 8'h00, 8'h00}, // SED
    '{4'd12, 8'h00, 4'd2, 8'h35, 8'hFC, 8'hFC, 8'h24, 1'b0, 8'h00, 8'h00}, // CLD
    '{4'd14, 8'h00, 4'd2, 8'h35, 8'hFC, 8'hFC, 8'h20, 1'b0, 8'h00, 8'h00}, // CLI
    '{4'd7,  8'hC0, 4'd2, 8'h35, 8'hFC, 8'hFC, 8'hE2, 1'b0, 8'h00, 8'h00}, // BIT
    '{4'd15, 8'h00, 4'd2, 8'h35, 8'hFC, 8'hFC, 8'hA2, 1'b0, 8'h00, 8'h00}, // CLV
    '{4'd0,  8'h00, 4'd2, 8'h35, 8'hFC, 8'hFC, 8'hA2, 1'b0, 8'h00, 8'h00}, // NOP
    '{4'd13, 8'h00, 4'd2, 8'h35, 8'hFC, 8'hFC, 8'hA6, 1'b0, 8'h00, 8'h00}, // SEI
    '{4'd14, 8'h00, 4'd2, 8'h35, 8'hFC, 8'hFC, 8'hA2, 1'b0, 8'h00, 8'h00}, // CLI
    '{4'd5,  8'h00, 4'd2, 8'h35, 8'hFC, 8'hFC, 8'hA2, 1'b0, 8'h00, 8'h00}, // TXS R8
    '{4'd8,  8'h00, 4'd3, 8'h35, 8'hFC, 8'hFB, 8'hA6, 1'b1, 8'hFC, 8'hB2}, // BRK R10
    '{4'd4,  8'h00, 4'd4, 8'h35, 8'hFC, 8'hFC, 8'hA2, 1'b0, 8'h00, 8'h00}, // PLP R7
    '{4'd3,  8'h00, 4'd4, 8'h35, 8'hFC, 8'hFD, 8'h20, 1'b0, 8'h00, 8'h00}  // PLA R6
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [7:0] d, output int cyc,
                        output logic wr, output logic [15:0] wa, output logic [7:0] wd,
                        output int ndone);
    int n;
    wr = 1'b0; wa = '0; wd = '0; ndone = 0; n = 0;
    @(negedge clk);
    op_code = o; operand = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    forever begin
      if (mem_we) begin wr = 1'b1; wa = mem_addr; wd = mem_wdata; end
      if (done) begin ndone++; break; end
      if (n > 20) break;
      @(negedge clk);
      n++;
    end
    cyc = n + 1;
    @(negedge clk);
    if (done) ndone++;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, nd;
    logic wr;
    logic [15:0] wa;
    logic [7:0] wd;
    for (int k = 0; k < 256; k++) smem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 a", 16'(a_out), 16'h00);
    chk("R1 x", 16'(x_out), 16'h00);
    chk("R1 s", 16'(s_out), 16'hFD);
    chk("R1 p", 16'(p_out), 16'h24);
    chk("R1 done/we", {14'd0, done, mem_we}, 16'h0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = TBL[k];
      run_op(v.op, v.opnd, cyc, wr, wa, wd, nd);
      chk($sformatf("R2 cycles row %0d", k), 16'(cyc), 16'(v.cyc));
      chk($sformatf("R2 done pulse row %0d", k), 16'(nd), 16'd1);
      chk($sformatf("R4 R6 R9 a row %0d", k), 16'(a_out), 16'(v.a));
      chk($sformatf("R8 x row %0d", k), 16'(x_out), 16'(v.x));
      chk($sformatf("R4 R6 R8 s row %0d", k), 16'(s_out), 16'(v.s));
      chk($sformatf("R5 R7 R9 R10 R11 p row %0d", k), 16'(p_out), 16'(v.p));
      chk($sformatf("R4 write flag row %0d", k), 16'(wr), 16'(v.wr));
      if (v.wr) begin
        chk($sformatf("R4 write addr row %0d", k), wa, {8'h01, v.wlo});
        chk($sformatf("R5 R10 write data row %0d", k), 16'(wd), 16'(v.wd));
      end
    end

    // R3: start raised during a push is ignored (SEC must not run)
    @(negedge clk);
    op_code = 4'd1; start = 1'b1;
    @(negedge clk);
    op_code = 4'd9;
    nd = 0;
    for (int k = 0; k < 6; k++) begin
      if (done) nd++;
      @(negedge clk);
      start = 1'b0;
    end
    chk("R3 single done", 16'(nd), 16'd1);
    chk("R3 carry untouched", 16'(p_out[0]), 16'd0);
    chk("R3 s after one push", 16'(s_out), 16'hFC);

    // R12: push down to S=0x00, then wrap
    while (s_out != 8'h00) run_op(4'd1, 8'h00, cyc, wr, wa, wd, nd);
    run_op(4'd1, 8'h00, cyc, wr, wa, wd, nd);
    chk("R12 push addr at S=00", wa, 16'h0100);
    chk("R12 s wraps to FF", 16'(s_out), 16'hFF);
    smem[8'h00] = 8'h9C;
    smem[8'h01] = 8'h10;
    smem[8'h02] = 8'hDF;
    run_op(4'd3, 8'h00, cyc, wr, wa, wd, nd);
    chk("R12 pull reads 0100", 16'(a_out), 16'h9C);
    chk("R12 s wraps to 00", 16'(s_out), 16'h00);
    chk("R6 N from pulled byte", 16'(p_out), 16'hA0);
    // R13: pulled bit4=1 / bit5=0 are overridden
    run_op(4'd4, 8'h00, cyc, wr, wa, wd, nd);
    chk("R13 R7 plp 10", 16'(p_out), 16'h20);
    run_op(4'd4, 8'h00, cyc, wr, wa, wd, nd);
    chk("R13 R7 plp DF", 16'(p_out), 16'hEF);
    run_op(4'd6, 8'h00, cyc, wr, wa, wd, nd);
    chk("R8 tsx x", 16'(x_out), 16'h02);
    chk("R8 tsx nz", 16'(p_out), 16'h6D);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule